// File: doc/BRIEF.md
# Two-to-Three Ratio Clock Gearbox

This block moves data words between two related clocks whose frequencies stand in a 2:3 ratio, a slow clock and a fast clock, both derived from one reference so that one rising edge in every three fast cycles coincides with a slow rising edge. The block has no FIFO and no synchronizer chain. It relies on the fixed phase relationship instead. A three-state phase sequencer in the fast domain labels every fast rising edge as phase 1, 2 or 3. Phase 1 is the edge shared with the slow clock. Each direction opens its capture only on the phase-2 and phase-3 edges.

The sequencer states are PH1, PH2 and PH3. Its transitions are PH1→PH2, PH2→PH3 and PH3→PH1. A high `beat_align` sampled at any fast edge forces that edge to be treated as PH1, and the sequence then resumes with PH2. In the fast-to-slow direction, a one-word hold stage loads only on phase-2 and phase-3 edges, so at most two words are accepted in any three fast cycles. `f2s_in_ready` tells the producer which cycles are open. In the slow-to-fast direction, every slow edge registers the incoming word, and the fast side copies it on the first non-shared fast edge after that slow edge. On the shared edge the fast side is masked, because at that edge it would see a value it has already taken.

Top module: `ratio_gearbox`

## Requirements
- R1: The fast-domain phase advances 1→2→3→1 on successive fast edges. A fast edge at which `beat_align` is high is phase 1, and the next edge is phase 2.
- R2: `f2s_in_ready` is high during a fast cycle exactly when the edge that closes that cycle is phase 2 or phase 3, and low when that edge is phase 1.
- R3: A fast-side word is accepted at a fast edge when `f2s_in_valid` and `f2s_in_ready` are both high. A word offered while ready is low is not taken, and the producer must keep it unchanged until it is accepted. The hold stage does not change at a phase-1 edge.
- R4: Every accepted fast-side word appears exactly once on `f2s_out_valid`/`f2s_out_data`, in acceptance order, after the first slow edge that follows its acceptance.
- R5: At every slow edge, `s2f_in_valid`/`s2f_in_data` are registered. At the next phase-2 or phase-3 fast edge, `s2f_out_valid` takes the registered valid bit and, when that bit is set, `s2f_out_data` takes the registered word. `s2f_out_valid` then stays for one fast cycle.
- R6: `s2f_out_valid` is low in every fast cycle that begins at a phase-1 edge.
- R7: Every slow-side word with valid high appears exactly once on the fast output, in order.
- R8: While `rst_n` is low, `f2s_in_ready`, `f2s_out_valid` and `s2f_out_valid` are low. The sequencer takes the first fast edge after reset release as phase 1.
- R9: After a reset released at the wrong phase, a single-cycle `beat_align` pulse before a shared edge restores the correct ready pattern from then on, with no other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast clock (3 cycles per common beat) |
| slow_clk | input | 1 | Slow clock (2 cycles per common beat) |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| beat_align | input | 1 | High for the fast cycle ending at a shared edge |
| f2s_in_valid | input | 1 | Fast-side word offered |
| f2s_in_data | input | DATA_W | Fast-side word |
| f2s_in_ready | output | 1 | Next fast edge accepts a word |
| f2s_out_valid | output | 1 | Word delivered in the slow domain |
| f2s_out_data | output | DATA_W | Delivered word, slow domain |
| s2f_in_valid | input | 1 | Slow-side word offered |
| s2f_in_data | input | DATA_W | Slow-side word |
| s2f_out_valid | output | 1 | Word delivered in the fast domain |
| s2f_out_data | output | DATA_W | Delivered word, fast domain |

## Verification
The bench builds both clocks from one reference and sweeps four valid patterns in each direction, from back-to-back words to sparse and irregular ones. It checks the exact ready pattern each cycle, the slow word expected on every open fast edge, and the masked shared edge. If the shared edge were not masked, every word sent on the second slow edge of a beat would arrive twice. If the hold stage loaded on the shared edge, words would be lost on the slow side. Both faults show up as order or count mismatches. A reset released at the wrong phase, followed by an alignment pulse, checks that the sequencer resynchronises from the pulse alone. A sequencer that ignored the pulse would keep a shifted ready pattern.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    // Label of a fast rising edge within the common beat; PH1 is the shared edge.
    typedef enum logic [1:0] {
        PH1 = 2'd1,
        PH2 = 2'd2,
        PH3 = 2'd3
    } phase_t;

    localparam int FAST_PER_BEAT = 3;
    localparam int SLOW_PER_BEAT = 2;

endpackage

// File: rtl/gbx_phase_seq.sv
module gbx_phase_seq
    import gbx_pkg::*;
(
    input  logic   fast_clk,
    input  logic   rst_n,
    input  logic   align,
    output phase_t edge_phase,
    output logic   open_edge
);

    phase_t ph_q;
    phase_t ph_d;

    // Phase carried by the upcoming fast edge; alignment overrides the count.
    always_comb begin
        edge_phase = align ? PH1 : ph_q;
        unique case (edge_phase)
            PH1:     ph_d = PH2;
            PH2:     ph_d = PH3;
            PH3:     ph_d = PH1;
            default: ph_d = PH1;
        endcase
    end

    // State register
    always_ff @(posedge fast_clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH1;
        else        ph_q <= ph_d;
    end

    // Outputs
    always_comb begin
        open_edge = (edge_phase != PH1);
    end

    // R1: a phase-3 edge is always followed by an expected phase 1
    a_r1_phase_advance: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (edge_phase == PH3) |=> (ph_q == PH1));

endmodule

// File: rtl/gbx_fast_to_slow.sv
module gbx_fast_to_slow #(
    parameter int DATA_W = 16
) (
    input  logic              fast_clk,
    input  logic              slow_clk,
    input  logic              rst_n,
    input  logic              open_edge,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int HOLD_W = DATA_W + 1;

    logic [HOLD_W-1:0] hold_q;

    // Fast side: load only on open edges, so a shared edge never overwrites.
    always_ff @(posedge fast_clk or negedge rst_n) begin
        if (!rst_n)         hold_q <= '0;
        else if (open_edge) hold_q <= {in_valid, in_data};
    end

    // Slow side: every slow edge sees exactly one fresh load.
    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= hold_q[HOLD_W-1];
            out_data  <= hold_q[DATA_W-1:0];
        end
    end

    // R3: the hold stage is left untouched across a shared edge
    a_r3_hold_stable: assert property (@(posedge fast_clk) disable iff (!rst_n)
        !open_edge |=> $stable(hold_q));

endmodule

// File: rtl/gbx_slow_to_fast.sv
module gbx_slow_to_fast #(
    parameter int DATA_W = 16
) (
    input  logic              fast_clk,
    input  logic              slow_clk,
    input  logic              rst_n,
    input  logic              open_edge,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic              src_v_q;
    logic [DATA_W-1:0] src_d_q;

    // Slow side launch register
    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            src_v_q <= 1'b0;
            src_d_q <= '0;
        end else begin
            src_v_q <= in_valid;
            src_d_q <= in_data;
        end
    end

    // Fast side capture, masked on the shared edge to avoid a second copy.
    always_ff @(posedge fast_clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (open_edge) begin
            out_valid <= src_v_q;
            if (src_v_q) out_data <= src_d_q;
        end else begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/ratio_gearbox.sv
module ratio_gearbox
    import gbx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              fast_clk,
    input  logic              slow_clk,
    input  logic              rst_n,
    input  logic              beat_align,
    input  logic              f2s_in_valid,
    input  logic [DATA_W-1:0] f2s_in_data,
    output logic              f2s_in_ready,
    output logic              f2s_out_valid,
    output logic [DATA_W-1:0] f2s_out_data,
    input  logic              s2f_in_valid,
    input  logic [DATA_W-1:0] s2f_in_data,
    output logic              s2f_out_valid,
    output logic [DATA_W-1:0] s2f_out_data
);

    phase_t edge_phase;
    logic   open_edge;

    gbx_phase_seq u_seq (
        .fast_clk   (fast_clk),
        .rst_n      (rst_n),
        .align      (beat_align),
        .edge_phase (edge_phase),
        .open_edge  (open_edge)
    );

    gbx_fast_to_slow #(.DATA_W(DATA_W)) u_f2s (
        .fast_clk  (fast_clk),
        .slow_clk  (slow_clk),
        .rst_n     (rst_n),
        .open_edge (open_edge),
        .in_valid  (f2s_in_valid),
        .in_data   (f2s_in_data),
        .out_valid (f2s_out_valid),
        .out_data  (f2s_out_data)
    );

    gbx_slow_to_fast #(.DATA_W(DATA_W)) u_s2f (
        .fast_clk  (fast_clk),
        .slow_clk  (slow_clk),
        .rst_n     (rst_n),
        .open_edge (open_edge),
        .in_valid  (s2f_in_valid),
        .in_data   (s2f_in_data),
        .out_valid (s2f_out_valid),
        .out_data  (s2f_out_data)
    );

    assign f2s_in_ready = rst_n && open_edge;

    // R2: two open cycles in a row are always followed by a blocked one
    a_r2_two_open_then_block: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (f2s_in_ready && $past(f2s_in_ready)) |=> !f2s_in_ready);

    // R6: nothing is delivered in the cycle after a shared edge
    a_r6_shared_edge_masked: assert property (@(posedge fast_clk) disable iff (!rst_n)
        !f2s_in_ready |=> !s2f_out_valid);

    // R3: an offered word that was refused is still offered, unchanged
    a_r3_producer_holds: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (f2s_in_valid && !f2s_in_ready) |=> (f2s_in_valid && $stable(f2s_in_data)));

endmodule

// File: tb/tb_ratio_gearbox.sv
`timescale 1ns/1ps
module tb_ratio_gearbox;

    localparam int DW = 16;

    logic ref_clk = 1'b0;
    logic fast_clk = 1'b0;
    logic slow_clk = 1'b0;
    int   r6 = 5;

    logic          rst_n = 1'b0;
    logic          beat_align = 1'b0;
    logic          f2s_in_valid = 1'b0;
    logic [DW-1:0] f2s_in_data = '0;
    logic          f2s_in_ready;
    logic          f2s_out_valid;
    logic [DW-1:0] f2s_out_data;
    logic          s2f_in_valid = 1'b0;
    logic [DW-1:0] s2f_in_data = '0;
    logic          s2f_out_valid;
    logic [DW-1:0] s2f_out_data;

    ratio_gearbox #(.DATA_W(DW)) dut (
        .fast_clk      (fast_clk),
        .slow_clk      (slow_clk),
        .rst_n         (rst_n),
        .beat_align    (beat_align),
        .f2s_in_valid  (f2s_in_valid),
        .f2s_in_data   (f2s_in_data),
        .f2s_in_ready  (f2s_in_ready),
        .f2s_out_valid (f2s_out_valid),
        .f2s_out_data  (f2s_out_data),
        .s2f_in_valid  (s2f_in_valid),
        .s2f_in_data   (s2f_in_data),
        .s2f_out_valid (s2f_out_valid),
        .s2f_out_data  (s2f_out_data)
    );

    // 250 MHz reference; fast = /2, slow = /3; r6 == 0 marks the shared edge.
    always #2 ref_clk = ~ref_clk;
    always @(posedge ref_clk) begin
        int nx;
        nx = (r6 == 5) ? 0 : r6 + 1;
        r6       <= nx;
        fast_clk <= (nx % 2 == 0);
        slow_clk <= (nx == 0) || (nx == 3);
    end

    int  checks = 0;
    int  failures = 0;
    bit  finished = 1'b0;
    bit  chk_ready = 1'b0;
    bit  chk_s2f = 1'b0;
    int  sent_f = 0, rcv_f = 0, sent_s = 0, rcv_s = 0;
    logic          last_s_v = 1'b0;
    logic [DW-1:0] last_s_d = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit want(input int pat, input int c);
        case (pat)
            0: return 1'b1;
            1: return (c % 2) == 0;
            2: return (c % 3) == 0;
            default: return ((c * 7 + 3) % 5) < 3;
        endcase
    endfunction

    task automatic wait_fast_r6(input int v);
        do begin @(posedge fast_clk); #1; end while (r6 != v);
    endtask

    // R2 ready pattern: closing edge at r6==0 is phase 1
    initial forever begin
        @(posedge fast_clk); #3;
        if (chk_ready)
            check(f2s_in_ready == (r6 != 4), "R2 ready pattern", f2s_in_ready, r6 != 4);
    end

    // Fast-side sink for slow-to-fast words: R5, R6, R7
    initial forever begin
        @(posedge fast_clk); #1;
        if (chk_s2f) begin
            if (r6 == 0) check(!s2f_out_valid, "R6 shared edge masked", s2f_out_valid, 0);
            else begin
                check(s2f_out_valid == last_s_v, "R5 valid after slow edge", s2f_out_valid, last_s_v);
                if (s2f_out_valid) begin
                    check(s2f_out_data == last_s_d, "R5 data after slow edge", s2f_out_data, last_s_d);
                    check(s2f_out_data == DW'(rcv_s), "R7 order", s2f_out_data, rcv_s);
                    rcv_s++;
                end
            end
        end
    end

    // Slow-side sink for fast-to-slow words: R4
    initial forever begin
        @(posedge slow_clk); #1;
        if (rst_n && f2s_out_valid) begin
            check(f2s_out_data == DW'(16'h4000 + rcv_f), "R4 order", f2s_out_data, 16'h4000 + rcv_f);
            rcv_f++;
        end
    end

    task automatic f2s_run(input int pat, input int ncyc);
        bit pend = 1'b0;
        for (int c = 0; c < ncyc || pend; c++) begin
            @(posedge fast_clk); #1;
            if (!pend && c < ncyc && want(pat, c)) begin
                pend = 1'b1;
                f2s_in_data = DW'(16'h4000 + sent_f);
            end
            f2s_in_valid = pend;
            #2;
            if (pend && f2s_in_ready) begin   // R3: taken at the coming edge
                sent_f++;
                pend = 1'b0;
            end
        end
        @(posedge fast_clk); #1;
        f2s_in_valid = 1'b0;
    endtask

    task automatic s2f_run(input int pat, input int ncyc);
        for (int c = 0; c < ncyc; c++) begin
            @(posedge slow_clk); #1;
            last_s_v = s2f_in_valid;
            last_s_d = s2f_in_data;
            s2f_in_valid = want(pat, c);
            s2f_in_data  = DW'(sent_s);
            if (s2f_in_valid) sent_s++;
        end
        @(posedge slow_clk); #1;
        last_s_v = s2f_in_valid;
        last_s_d = s2f_in_data;
        s2f_in_valid = 1'b0;
        @(posedge slow_clk); #1;
        last_s_v = 1'b0;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge fast_clk);
        #3;
        check(!f2s_in_ready, "R8 reset ready", f2s_in_ready, 0);
        check(!f2s_out_valid, "R8 reset f2s valid", f2s_out_valid, 0);
        check(!s2f_out_valid, "R8 reset s2f valid", s2f_out_valid, 0);
        wait_fast_r6(4);
        rst_n = 1'b1;
        chk_ready = 1'b1;
        chk_s2f = 1'b1;
        fork
            for (int p = 0; p < 4; p++) f2s_run(p, 60);
            for (int p = 0; p < 4; p++) s2f_run(p, 40);
            begin   // R1: alignment at a correct shared edge changes nothing
                for (int k = 0; k < 3; k++) begin
                    repeat (10) @(posedge fast_clk);
                    wait_fast_r6(4);
                    beat_align = 1'b1;
                    @(posedge fast_clk); #1;
                    beat_align = 1'b0;
                end
            end
        join
        repeat (20) @(posedge fast_clk);
        #1;
        check(rcv_f == sent_f, "R4 count", rcv_f, sent_f);
        check(rcv_s == sent_s, "R7 count", rcv_s, sent_s);
        check(sent_f > 100, "R3 words accepted", sent_f, 100);

        // R8/R9: reset released at the wrong phase, then realigned
        chk_ready = 1'b0;
        chk_s2f = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge fast_clk);
        wait_fast_r6(0);
        rst_n = 1'b1;
        #2;
        check(!f2s_in_ready, "R8 first edge after release is phase 1", f2s_in_ready, 0);
        wait_fast_r6(4);
        beat_align = 1'b1;
        #2;
        check(!f2s_in_ready, "R9 align blocks shared edge", f2s_in_ready, 0);
        @(posedge fast_clk); #1;
        beat_align = 1'b0;
        chk_ready = 1'b1;
        repeat (12) @(posedge fast_clk);
        #3;
        chk_ready = 1'b0;
        check(rcv_f == sent_f, "R9 no stray delivery", rcv_f, sent_f);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule